// File: doc/BRIEF.md
# Bit-Serial Finite-Field Multiplier

The block multiplies two elements of a binary extension field of four bits, GF(2^4), in polynomial basis. The field polynomial is given by its low-order coefficients on a 4-bit input. The leading t^4 term is implied. A start pulse captures both operands and the field polynomial. The accumulator is cleared at the same time.

The block then takes one bit of the second operand per cycle, most significant bit first. On each step it shifts the accumulator left and adds the first operand when that bit is set. It also folds in the field polynomial when the bit leaving the accumulator was set, so reduction happens inside each step. A one-hot shift register sequences the steps. Its top stage marks the cycle in which the product is presented.

Callers pulse `start` with the inputs valid. They read `product` in the single cycle in which `done` is high. A new `start` may be issued at any time. It abandons any multiplication still in progress.

Top module: `gf_bitserial_mul`

## Requirements
- R1: After reset is released, `done` is 0 and `product` is 0000 until a start is accepted.
- R2: When `start` is high at a rising edge, `done` is high only in the cycle that follows the fourth rising edge after that one, and it is low again after the fifth, unless a later start intervenes.
- R3: The product in the `done` cycle is (A·B) mod (t^4 + P), where P is `poly_low` with bit i the coefficient of t^i. For example, with P = 0011, 1001 × 0110 gives 0011.
- R4: Whenever `done` is low, `product` reads 0000.
- R5: `op_a`, `op_b` and `poly_low` are captured only at the edge where `start` is high. Changes to them during a multiplication do not alter its result.
- R6: A start accepted while a multiplication is running abandons it. Exactly one `done` follows, timed from the latest start and carrying the product of the latest operands.
- R7: Multiplying any operand by 0001 returns that operand unchanged. Multiplying by 0000, on either side, returns 0000.
- R8: The reduction follows the supplied polynomial. With P = 1001 (t^4 + t^3 + 1), every product matches that field and not the one given by 0011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture inputs and begin a multiplication |
| poly_low | input | W | Low-order coefficients of the field polynomial |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier, consumed most significant bit first |
| product | output | W | Result, valid while `done` is high, otherwise zero |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its default width W = 4. At that width the sequencer is five stages long and the full operand space has only 256 pairs. This makes every product in two different fields reachable exhaustively, once with polynomial 0011 and once with 1001. Each multiplication also checks the exact done cycle and a zero output in all the other cycles. Scrambled inputs after the start and restarts in the middle of a run show that capture happens only at start.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  localparam int unsigned MAX_W = 16;

  typedef logic [MAX_W-1:0] gf_word_t;

  // One interleaved shift/add/reduce step over a field of width w.
  function automatic gf_word_t gf_step(input gf_word_t acc, input gf_word_t a,
                                       input gf_word_t poly, input logic b_top,
                                       input int unsigned w);
    gf_word_t mask;
    gf_word_t nxt;
    mask = {MAX_W{1'b1}} >> (MAX_W - w);
    nxt  = acc << 1;
    if (b_top) nxt = nxt ^ a;
    if (acc[w-1]) nxt = nxt ^ poly;
    return nxt & mask;
  endfunction
endpackage

// File: rtl/gfm_seq.sv
module gfm_seq #(
  parameter int unsigned W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic [W:0] ctl,
  output logic       step_en,
  output logic       fin
);
  localparam int unsigned STAGES = W + 1;
  localparam logic [STAGES-1:0] SEED = STAGES'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl <= '0;
    else if (start) ctl <= SEED;
    else            ctl <= {ctl[W-1:0], 1'b0};
  end

  assign step_en = |ctl[W-1:0];
  assign fin     = ctl[W];
endmodule

// File: rtl/gfm_opregs.sv
module gfm_opregs #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] p_in,
  output logic [W-1:0] a_q,
  output logic [W-1:0] p_q,
  output logic         b_top
);
  logic [W-1:0] b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      p_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= a_in;
      p_q <= p_in;
      b_q <= b_in;
    end else if (shift) begin
      b_q <= {b_q[W-2:0], 1'b0};
    end
  end

  assign b_top = b_q[W-1];
endmodule

// File: rtl/gfm_accum.sv
module gfm_accum
  import gfm_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] a_q,
  input  logic [W-1:0] p_q,
  input  logic         b_top,
  output logic [W-1:0] acc
);
  gf_word_t acc_w, a_w, p_w, nxt_w;

  assign acc_w = gf_word_t'(acc);
  assign a_w   = gf_word_t'(a_q);
  assign p_w   = gf_word_t'(p_q);
  assign nxt_w = gf_step(acc_w, a_w, p_w, b_top, W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (step)  acc <= nxt_w[W-1:0];
  end
endmodule

// File: rtl/gf_bitserial_mul.sv
module gf_bitserial_mul #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] poly_low,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] product,
  output logic         done
);
  logic [W:0]   ctl;
  logic         step_en;
  logic         fin;
  logic         do_step;
  logic [W-1:0] a_q;
  logic [W-1:0] p_q;
  logic         b_top;
  logic [W-1:0] acc;

  assign do_step = step_en & ~start;

  gfm_seq #(.W(W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ctl(ctl), .step_en(step_en), .fin(fin)
  );

  gfm_opregs #(.W(W)) ops_i (
    .clk(clk), .rst_n(rst_n), .load(start), .shift(do_step),
    .a_in(op_a), .b_in(op_b), .p_in(poly_low),
    .a_q(a_q), .p_q(p_q), .b_top(b_top)
  );

  gfm_accum #(.W(W)) acc_i (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(do_step),
    .a_q(a_q), .p_q(p_q), .b_top(b_top), .acc(acc)
  );

  assign done    = fin;
  assign product = fin ? acc : '0;
endmodule

// File: rtl/gfm_chk.sv
module gfm_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W:0]   ctl,
  input logic [W-1:0] acc,
  input logic [W-1:0] a_q,
  input logic [W-1:0] p_q,
  input logic         done,
  input logic [W-1:0] product
);
  // R2: the sequencer never holds more than one token
  a_r2_onehot_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl));

  // R2: done lasts a single cycle
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a start reseeds the sequencer
  a_r6_restart_seed: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ctl == (W+1)'(1)));

  // R6: a start clears the accumulator
  a_r6_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc == '0));

  // R5: captured operand and polynomial stay put between starts
  a_r5_hold_captured: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(a_q) && $stable(p_q)));

  // R7: a zero multiplicand yields zero
  a_r7_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (done && a_q == '0) |-> (product == '0));
endmodule

bind gf_bitserial_mul gfm_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .ctl(ctl), .acc(acc),
  .a_q(a_q), .p_q(p_q), .done(done), .product(product)
);

// File: tb/gf_bitserial_mul_tb_top.sv
module gf_bitserial_mul_tb_top;
  localparam int unsigned W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] poly_low = '0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] product;
  logic         done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gf_bitserial_mul #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .poly_low(poly_low),
    .op_a(op_a), .op_b(op_b), .product(product), .done(done)
  );

  // Reference: full carry-less product, then reduce from the top down.
  function automatic logic [3:0] ref_mul(input logic [3:0] a, input logic [3:0] b,
                                         input logic [3:0] p);
    logic [7:0] full;
    full = '0;
    for (int i = 0; i < 4; i++)
      if (b[i]) full = full ^ (8'(a) << i);
    for (int k = 6; k >= 4; k--)
      if (full[k]) full = full ^ (8'({1'b1, p}) << (k - 4));
    return full[3:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Starts one multiplication and checks every cycle up to the one after done.
  task automatic run_mul(input logic [3:0] a, input logic [3:0] b,
                         input logic [3:0] p, input string req);
    logic [3:0] exp_v;
    exp_v = ref_mul(a, b, p);
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b; poly_low = p;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; op_a = ~a; op_b = ~b; poly_low = ~p;  // R5 scramble
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 4) begin
        chk(done == 1'b1, "R2", int'(done), 1);
        chk(product == exp_v, req, int'(product), int'(exp_v));
      end else begin
        chk(done == 1'b0, "R2", int'(done), 0);
        chk(product == 4'd0, "R4", int'(product), 0);
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", int'(done), 0);
    chk(product == 4'd0, "R1", int'(product), 0);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(done == 1'b0 && product == 4'd0, "R1", int'(product), 0);
    end
  endtask

  task automatic t_example();
    chk(ref_mul(4'b1001, 4'b0110, 4'b0011) == 4'b0011, "R3", 3, 3);
    run_mul(4'b1001, 4'b0110, 4'b0011, "R3");
  endtask

  task automatic t_sweep(input logic [3:0] p, input string req);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_mul(4'(a), 4'(b), p, req);
  endtask

  task automatic t_identity();
    for (int a = 0; a < 16; a++) begin
      run_mul(4'(a), 4'b0001, 4'b0011, "R7");
      run_mul(4'b0000, 4'(a), 4'b0011, "R7");
    end
  endtask

  task automatic t_field_differs();
    // R8: 1001 x 0110 differs between the two fields
    chk(ref_mul(4'b1001, 4'b0110, 4'b1001) != ref_mul(4'b1001, 4'b0110, 4'b0011),
        "R8", int'(ref_mul(4'b1001, 4'b0110, 4'b1001)), 3);
    run_mul(4'b1001, 4'b0110, 4'b1001, "R8");
  endtask

  task automatic t_restart();
    logic [3:0] exp_v;
    exp_v = ref_mul(4'b1011, 4'b0111, 4'b0011);
    @(negedge clk);
    start = 1'b1; op_a = 4'b1111; op_b = 4'b1111; poly_low = 4'b0011;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R6", int'(done), 0);
    end
    start = 1'b1; op_a = 4'b1011; op_b = 4'b0111; poly_low = 4'b0011;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; op_a = 4'b0000; op_b = 4'b0000;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 4) begin
        chk(done == 1'b1, "R6", int'(done), 1);
        chk(product == exp_v, "R6", int'(product), int'(exp_v));
      end else begin
        chk(done == 1'b0, "R6", int'(done), 0);
      end
    end
  endtask

  initial begin
    t_reset();
    t_example();
    t_identity();
    t_field_differs();
    t_restart();
    t_sweep(4'b0011, "R3");
    t_sweep(4'b1001, "R8");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule